// File: doc/BRIEF.md
# Register-stack spill/fill controller

This block keeps the top of a runtime stack in a 64-entry circular local register file. Older frames live in memory. The controller holds the frame pointer and the frame length of the current frame as absolute stack positions. It maps a frame-relative register index onto a physical entry by taking the position modulo the register count. A call places a new frame directly above the current one. A return restores the caller's frame, whose length the return supplies.

The current frame must always be resident. When a call pushes the resident span past the register file's capacity, the controller stalls and copies the oldest resident registers out to memory, one word per cycle. It continues until the span fits again. When a return goes back to a frame that has been partly copied out, the controller stalls and reads the missing words back, one per cycle, highest address first.

The memory stack pointer is the position of the oldest resident register. Before each spill write, it is compared with an upper bound input. A spill write that would take the pointer past the bound is not issued. Instead, a trap is raised and the block stays stalled until reset. Software takes no part in any of this traffic.

Top module: `regstack_ctl`

## Requirements
- R1: After reset, sp_o is 0, stall_o, trap_o, mem_we_o and mem_re_o are 0, and the current frame has length 0.
- R2: rd_data_o returns the register at physical entry (fp + rd_idx_i) mod 64, where fp is the frame's absolute position. An accepted call moves fp up by the current frame length and sets the length to call_len_i+1. An accepted return moves fp down by ret_len_i+1 and sets the length to ret_len_i+1.
- R3: A register write with wr_idx_i not less than the current frame length has no effect on any register. So has a write while stall_o is high.
- R4: While the resident span (fp + length - sp) exceeds 64, the block spills. Each cycle it asserts mem_we_o with mem_addr_o = sp_o and mem_wdata_o = the register at entry sp_o mod 64. sp_o then increments.
- R5: While fp < sp_o, the block fills. Each cycle it asserts mem_re_o with mem_addr_o = sp_o-1 and loads mem_rdata_i into entry (sp_o-1) mod 64. sp_o then decrements.
- R6: stall_o is high exactly while a spill or fill is pending or trap_o is set. Calls and returns presented while stall_o is high are ignored. sp_o is unchanged in any cycle without a spill or fill.
- R7: If a spill is pending and sp_o+1 exceeds bound_i, trap_o rises and no write is issued. trap_o and stall_o then stay high until reset.
- R8: A return with ret_len_i+1 greater than fp is ignored. A call takes priority over a return in the same cycle.
- R9: mem_we_o and mem_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe |
| call_len_i | input | 4 | New frame length minus one |
| ret_i | input | 1 | Return strobe |
| ret_len_i | input | 4 | Caller frame length minus one |
| rd_idx_i | input | 4 | Frame-relative read index |
| rd_data_o | output | 32 | Read data |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 4 | Frame-relative write index |
| wr_data_i | input | 32 | Register write data |
| bound_i | input | 16 | Upper bound for the memory stack pointer |
| sp_o | output | 16 | Memory stack pointer (words spilled) |
| stall_o | output | 1 | Spill or fill in progress, or trapped |
| trap_o | output | 1 | Stack bound trap, sticky |
| mem_we_o | output | 1 | Spill write strobe |
| mem_re_o | output | 1 | Fill read strobe |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Spill write data |
| mem_rdata_i | input | 32 | Fill read data, valid in the same cycle |

## Verification
The hardest situation to reach is a spill that runs into the bound partway through. The trap must cut off the write stream at exactly the right word. Reaching it takes a lowered bound after reset and a chain of full-length calls that grows the resident span past 64. The bench also covers two other hard cases: a return that crosses the circular wrap while refilling, and a frame whose aliased entries hold older data. Deep nesting followed by unwinding exercises the wrap. An earlier full-length frame placed at the same position leaves the older data in place, so that an out-of-frame write can be shown to leave it untouched.

// File: rtl/regstack_ctl.sv
module regstack_ctl #(
  parameter int NREG = 64,
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int MAXF = 16,
  localparam int LW  = $clog2(NREG),
  localparam int IW  = $clog2(MAXF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic [IW-1:0] call_len_i,
  input  logic          ret_i,
  input  logic [IW-1:0] ret_len_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] bound_i,
  output logic [AW-1:0] sp_o,
  output logic          stall_o,
  output logic          trap_o,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);

  logic [DW-1:0] rf [NREG];
  logic [AW-1:0] fp, bot;
  logic [IW:0]   len;
  logic          trap;

  logic [AW-1:0] top, used, bot_m1, rd_abs, wr_abs;
  logic [IW:0]   clen, rlen;
  logic          over, under, past_bound, wr_ok, call_ok, ret_ok;

  assign top        = fp + AW'(len);
  assign used       = top - bot;
  assign bot_m1     = bot - 1'b1;
  assign over       = used > AW'(NREG);
  assign under      = fp < bot;
  assign past_bound = ({1'b0, bot} + 1'b1) > {1'b0, bound_i};

  assign mem_we_o    = !trap && over && !past_bound;
  assign mem_re_o    = !trap && !over && under;
  assign stall_o     = trap || over || under;
  assign trap_o      = trap;
  assign sp_o        = bot;
  assign mem_addr_o  = mem_re_o ? bot_m1 : bot;
  assign mem_wdata_o = rf[bot[LW-1:0]];

  assign rd_abs    = fp + AW'(rd_idx_i);
  assign rd_data_o = rf[rd_abs[LW-1:0]];
  assign wr_abs    = fp + AW'(wr_idx_i);

  assign clen    = {1'b0, call_len_i} + 1'b1;
  assign rlen    = {1'b0, ret_len_i} + 1'b1;
  assign wr_ok   = !stall_o && wr_en_i && ({1'b0, wr_idx_i} < len);
  assign call_ok = !stall_o && call_i;
  assign ret_ok  = !stall_o && !call_i && ret_i && (fp >= AW'(rlen));

  always_ff @(posedge clk) begin
    if (mem_re_o)   rf[bot_m1[LW-1:0]] <= mem_rdata_i;
    else if (wr_ok) rf[wr_abs[LW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp   <= '0;
      bot  <= '0;
      len  <= '0;
      trap <= 1'b0;
    end else if (!trap) begin
      if (over) begin
        if (past_bound) trap <= 1'b1;
        else            bot  <= bot + 1'b1;
      end else if (under) begin
        bot <= bot_m1;
      end else if (call_ok) begin
        fp  <= top;
        len <= clen;
      end else if (ret_ok) begin
        fp  <= fp - AW'(rlen);
        len <= rlen;
      end
    end
  end

endmodule

// File: rtl/regstack_ctl_chk.sv
module regstack_ctl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] sp_o,
  input logic          stall_o,
  input logic          trap_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] bound_i
);

  p_spill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> sp_o == $past(sp_o) + 1'b1);

  p_spill_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_addr_o == sp_o);

  p_fill_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |=> sp_o == $past(sp_o) - 1'b1);

  p_fill_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> mem_addr_o == sp_o - 1'b1);

  p_idle_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_o |-> !mem_we_o && !mem_re_o);

  p_sp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_o && !mem_re_o) |=> $stable(sp_o));

  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ({1'b0, sp_o} + 1'b1) <= {1'b0, bound_i});

  p_trap_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> trap_o && stall_o && !mem_we_o);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

endmodule

bind regstack_ctl regstack_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sp_o(sp_o), .stall_o(stall_o), .trap_o(trap_o),
  .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
  .bound_i(bound_i)
);

// File: tb/regstack_ctl_tb.sv
`timescale 1ns/1ps
module regstack_ctl_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, call_i, ret_i, wr_en_i;
  logic [3:0]  call_len_i, ret_len_i, rd_idx_i, wr_idx_i;
  logic [31:0] wr_data_i, rd_data_o, mem_wdata_o, mem_rdata_i;
  logic [15:0] bound_i, sp_o, mem_addr_o;
  logic        stall_o, trap_o, mem_we_o, mem_re_o;

  regstack_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_len_i(call_len_i),
    .ret_i(ret_i), .ret_len_i(ret_len_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .bound_i(bound_i), .sp_o(sp_o),
    .stall_o(stall_o), .trap_o(trap_o), .mem_we_o(mem_we_o),
    .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  logic [31:0] bmem [1024];
  assign mem_rdata_i = bmem[mem_addr_o[9:0]];
  always @(posedge clk) if (mem_we_o) bmem[mem_addr_o[9:0]] <= mem_wdata_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  int m_fp, m_len, m_bot;
  bit m_trap;
  logic [31:0] mrf [64];
  bit          mk  [64];
  logic [31:0] mm  [1024];
  bit          mmk [1024];
  int stk [$];

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_over();  return (m_fp + m_len - m_bot) > 64; endfunction
  function automatic bit m_stall(); return m_trap || m_over() || (m_fp < m_bot); endfunction

  task automatic model_reset();
    m_fp = 0; m_len = 0; m_bot = 0; m_trap = 0;
    for (int i = 0; i < 64; i++) mk[i] = 0;
    stk.delete();
  endtask

  task automatic compare();
    bit ob, we, re;
    int ra;
    ob = (m_bot + 1) > int'(bound_i);
    we = !m_trap && m_over() && !ob;
    re = !m_trap && !m_over() && (m_fp < m_bot);
    cmp("R6 stall_o", {31'b0, stall_o}, {31'b0, m_stall()});
    cmp("R4 R5 sp_o", {16'b0, sp_o}, m_bot);
    cmp("R7 trap_o", {31'b0, trap_o}, {31'b0, m_trap});
    cmp("R4 R7 mem_we_o", {31'b0, mem_we_o}, {31'b0, we});
    cmp("R5 mem_re_o", {31'b0, mem_re_o}, {31'b0, re});
    cmp("R9 exclusive strobes", {31'b0, mem_we_o & mem_re_o}, 32'd0);
    if (we) cmp("R4 spill addr", {16'b0, mem_addr_o}, m_bot);
    if (re) cmp("R5 fill addr", {16'b0, mem_addr_o}, m_bot - 1);
    if (we && mk[m_bot % 64]) cmp("R4 spill data", mem_wdata_o, mrf[m_bot % 64]);
    ra = (m_fp + rd_idx_i) % 64;
    if (!m_stall() && rd_idx_i < m_len && mk[ra])
      cmp("R2 R3 R5 R8 rd_data_o", rd_data_o, mrf[ra]);
  endtask

  task automatic model_update();
    if (m_trap) begin
    end else if (m_over()) begin
      if (m_bot + 1 > int'(bound_i)) m_trap = 1;
      else begin
        mm[m_bot] = mrf[m_bot % 64]; mmk[m_bot] = mk[m_bot % 64]; m_bot++;
      end
    end else if (m_fp < m_bot) begin
      m_bot--; mrf[m_bot % 64] = mm[m_bot]; mk[m_bot % 64] = mmk[m_bot];
    end else begin
      if (wr_en_i && wr_idx_i < m_len) begin
        mrf[(m_fp + wr_idx_i) % 64] = wr_data_i; mk[(m_fp + wr_idx_i) % 64] = 1;
      end
      if (call_i) begin
        m_fp += m_len; m_len = call_len_i + 1;
      end else if (ret_i && m_fp >= ret_len_i + 1) begin
        m_fp -= ret_len_i + 1; m_len = ret_len_i + 1;
      end
    end
  endtask

  task automatic step();
    #1;
    compare();
    model_update();
    @(negedge clk);
  endtask

  task automatic wait_ns(); while (m_stall()) step(); endtask

  task automatic do_call(int n);
    wait_ns(); stk.push_back(m_len);
    call_i = 1; call_len_i = 4'(n - 1); step(); call_i = 0;
  endtask

  task automatic do_ret();
    int n;
    wait_ns(); n = stk.pop_back();
    ret_i = 1; ret_len_i = 4'(n - 1); step(); ret_i = 0;
  endtask

  task automatic do_wr(int idx, logic [31:0] d);
    wait_ns(); wr_en_i = 1; wr_idx_i = 4'(idx); wr_data_i = d; step(); wr_en_i = 0;
  endtask

  task automatic do_rd(int idx); wait_ns(); rd_idx_i = 4'(idx); step(); endtask

  task automatic fill_frame(int n); for (int i = 0; i < n; i++) do_wr(i, $urandom); endtask
  task automatic read_frame(int n); for (int i = 0; i < n; i++) do_rd(i); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic apply_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    cmp("R1 reset sp_o", {16'b0, sp_o}, 32'd0);
    cmp("R1 reset stall_o", {31'b0, stall_o}, 32'd0);
    cmp("R1 reset trap_o", {31'b0, trap_o}, 32'd0);
    cmp("R1 reset mem strobes", {30'b0, mem_we_o, mem_re_o}, 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    vectors++; miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    call_i = 0; ret_i = 0; wr_en_i = 0; call_len_i = 0; ret_len_i = 0;
    rd_idx_i = 0; wr_idx_i = 0; wr_data_i = 0; bound_i = 16'd900;
    @(negedge clk);
    apply_reset();

    // R3: write with zero-length frame, R8: return at depth 0
    do_wr(0, 32'hdead0000);
    ret_i = 1; ret_len_i = 4'd3; step(); ret_i = 0;
    step();

    // R4 R6: deep full-length calls force spills; call and write during stall ignored
    for (int d = 0; d < 8; d++) begin
      do_call(16);
      if (m_stall()) begin
        call_i = 1; call_len_i = 4'd4; step(); call_i = 0;
        wr_en_i = 1; wr_idx_i = 0; wr_data_i = 32'hbad0bad0; step(); wr_en_i = 0;
      end
      fill_frame(16);
      read_frame(16);
    end

    // R5: unwind across the wrap with fills
    for (int d = 0; d < 7; d++) begin
      do_ret();
      read_frame(16);
    end

    // R3: out-of-frame write leaves aliased older data
    do_call(16); fill_frame(16);
    do_ret();
    do_call(4);
    do_wr(10, 32'h5a5a5a5a);
    do_wr(3, 32'h01234567);
    do_ret();
    do_call(16); read_frame(16);
    do_ret();

    // R8: call wins over simultaneous return
    wait_ns();
    stk.push_back(m_len);
    call_i = 1; ret_i = 1; call_len_i = 4'd7; ret_len_i = 4'd0; step();
    call_i = 0; ret_i = 0;
    fill_frame(8); read_frame(8);

    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 9);
      if (op < 3 && m_fp < 700) begin
        int n = $urandom_range(1, 16);
        do_call(n); fill_frame(n);
      end else if (op < 6 && stk.size() > 0 && stk[$] > 0) begin
        do_ret(); do_rd($urandom_range(0, 15));
      end else if (op < 8) begin
        do_wr($urandom_range(0, 15), $urandom);
      end else begin
        do_rd($urandom_range(0, 15));
      end
    end
    while (stk.size() > 0 && stk[$] > 0) begin do_ret(); read_frame(m_len); end

    // R7: low bound, spill runs into it
    apply_reset();
    bound_i = 16'd20;
    for (int d = 0; d < 6 && !m_trap; d++) begin
      do_call(16);
      while (m_stall() && !m_trap) step();
      if (!m_trap) fill_frame(16);
    end
    for (int i = 0; i < 10; i++) begin
      call_i = (i == 2); ret_i = (i == 5); ret_len_i = 4'd0;
      step();
    end
    call_i = 0; ret_i = 0;
    cmp("R7 trap held", {31'b0, trap_o}, 32'd1);
    cmp("R7 sp at bound", {16'b0, sp_o}, 32'd20);

    finish_run();
  end

endmodule